// File: doc/BRIEF.md
# Memory-Mapped Test-and-Set Lock Engine

This block is a target on a shared-memory interconnect that gives several processors an array of binary lock slots for building spin locks. Each slot guards one shared object, for example a scheduler, a mutex or a semaphore. Software reaches the slots through an uncached address window, so every access goes to the hardware. A plain load from a slot is an atomic test-and-set: it returns the slot's old value and leaves the slot at 1. A plain store clears the slot to 0. Because the engine makes each access indivisible itself, the interconnect needs no locked or read-modify-write transactions.

Each requester has its own request channel, and the channel index is the requester ID. A request is accepted when valid and ready are both high. Its response appears one cycle later as a one-cycle pulse on the response lines of that channel. When several requests in one cycle touch the same slot, they take effect one after another in ascending requester ID.

When the parking input is high, a load that finds its slot held is queued on that slot instead of answered. The engine holds that requester's ready low and withholds its response, so the processor stalls instead of polling. When the slot is cleared, the oldest waiter is handed the lock directly.

Top module: `lkeng_top`

## Requirements
- R1: An accepted read of an in-range slot returns, one cycle later, the slot's value before the access in bit 0 of the read data, with bits 31..1 at 0. The slot is 1 afterwards.
- R2: An accepted write to an in-range slot with no waiters leaves that slot at 0, whether it was 0 or 1 before. Its response has the error flag 0 and read data 0.
- R3: Slots are independent. An access to one slot never changes the value of another slot.
- R4: An address equal to or above the slot count (default 32) gives a response with the error flag 1 and read data 0. It changes no slot.
- R5: Requests accepted in the same cycle take effect in ascending requester ID order. When several reads hit one free slot, only the lowest ID reads 0. A lower-ID read sees the slot before a higher-ID write clears it, and a higher-ID read sees it after a lower-ID write.
- R6: With parking low, every accepted request gets its response exactly one cycle after acceptance, and a read of a held slot returns 1.
- R7: With parking high, a read of a held slot gets no response. Its requester's ready stays low and its response valid stays low until the slot is handed to it.
- R8: A write to a slot that has waiters hands the lock to the waiter that queued first. That waiter gets read data 0 in the same cycle as the writer's response and becomes ready again. The slot stays at 1, and later waiters keep their queue order.
- R9: After reset all slots are 0, no requester is parked, every ready is 1 and every response valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| park_en | input | 1 | 1: a failed read waits in the slot's queue; 0: a failed read returns 1 |
| req_valid | input | NPORT | Request valid, one bit per requester |
| req_ready | output | NPORT | Request ready; low while that requester is parked |
| req_write | input | NPORT | 1 = write (release), 0 = read (test-and-set) |
| req_addr | input | NPORT*AW | Slot address, AW bits per requester |
| rsp_valid | output | NPORT | One-cycle response pulse per requester |
| rsp_rdata | output | NPORT*DW | Read data per requester; bit 0 is the old slot value |
| rsp_err | output | NPORT | Address out of range |

## Verification
The bench fires all requesters at one slot in the same cycle. A design without strict ordering by requester ID would hand out 0 more than once, or would let a write and a read in the same cycle see the wrong order. To catch a design that queues by requester ID instead of by arrival, or that frees a slot it should hand over, the bench queues a higher ID ahead of a lower ID. It then checks that the first release wakes only the earlier arrival and that the slot stays held. Out-of-range addresses are chosen to alias onto live slots, so a decoder that drops the upper address bits shows up as a slot that changed. Repeated writes to a free slot and a read of a held slot with parking off catch a write that toggles the slot and a read that stalls when it should answer.

// File: rtl/lkeng_pkg.sv
package lkeng_pkg;

    // Operation decoded from one requester channel in one cycle
    typedef enum logic [1:0] {
        LK_NONE = 2'd0,
        LK_ACQ  = 2'd1,
        LK_REL  = 2'd2,
        LK_BAD  = 2'd3
    } lk_op_e;

    // Response produced for one requester in one cycle
    typedef struct packed {
        logic vld;
        logic err;
        logic held;
    } lk_rsp_t;

    // Index width that never collapses to zero
    function automatic int lk_bits(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/lkeng_decode.sv
module lkeng_decode
    import lkeng_pkg::*;
#(
    parameter int NSLOT = 32,
    parameter int AW    = 8,
    parameter int SW    = 5
) (
    input  logic          valid,
    input  logic          parked,
    input  logic          write,
    input  logic [AW-1:0] addr,
    output lk_op_e        op,
    output logic [SW-1:0] slot
);

    localparam logic [AW-1:0] LIMIT = AW'(NSLOT);

    always_comb begin
        slot = addr[SW-1:0];
        if (!valid || parked)
            op = LK_NONE;
        else if (addr >= LIMIT)
            op = LK_BAD;
        else if (write)
            op = LK_REL;
        else
            op = LK_ACQ;
    end

endmodule

// File: rtl/lkeng_core.sv
module lkeng_core
    import lkeng_pkg::*;
#(
    parameter int NSLOT = 32,
    parameter int NPORT = 4,
    parameter int SW    = 5,
    parameter int PW    = 2,
    parameter int CW    = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          park_en,
    input  lk_op_e        op   [NPORT],
    input  logic [SW-1:0] slot [NPORT],
    output lk_rsp_t       rsp  [NPORT],
    output logic [NPORT-1:0] parked
);

    logic [NSLOT-1:0] slot_q, slot_n;
    logic [PW-1:0]    qid_q  [NSLOT][NPORT];
    logic [PW-1:0]    qid_n  [NSLOT][NPORT];
    logic [CW-1:0]    qcnt_q [NSLOT];
    logic [CW-1:0]    qcnt_n [NSLOT];
    logic [NPORT-1:0] park_q, park_n;

    // Requests are applied one after another in ascending requester ID
    always_comb begin
        logic [SW-1:0] s;
        logic [PW-1:0] w;
        s      = '0;
        w      = '0;
        slot_n = slot_q;
        qid_n  = qid_q;
        qcnt_n = qcnt_q;
        park_n = park_q;
        for (int p = 0; p < NPORT; p++) rsp[p] = '0;
        for (int p = 0; p < NPORT; p++) begin
            s = slot[p];
            case (op[p])
                LK_BAD: begin
                    rsp[p].vld = 1'b1;
                    rsp[p].err = 1'b1;
                end
                LK_REL: begin
                    rsp[p].vld = 1'b1;
                    if (qcnt_n[s] != '0) begin
                        // hand the lock to the oldest waiter, slot stays held
                        w = qid_n[s][0];
                        rsp[w].vld  = 1'b1;
                        rsp[w].held = 1'b0;
                        park_n[w]   = 1'b0;
                        for (int k = 0; k < NPORT - 1; k++)
                            qid_n[s][k] = qid_n[s][k+1];
                        qcnt_n[s] = qcnt_n[s] - CW'(1);
                    end else begin
                        slot_n[s] = 1'b0;
                    end
                end
                LK_ACQ: begin
                    if (!slot_n[s]) begin
                        rsp[p].vld = 1'b1;
                        slot_n[s]  = 1'b1;
                    end else if (park_en) begin
                        qid_n[s][PW'(qcnt_n[s])] = PW'(p);
                        qcnt_n[s] = qcnt_n[s] + CW'(1);
                        park_n[p] = 1'b1;
                    end else begin
                        rsp[p].vld  = 1'b1;
                        rsp[p].held = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            park_q <= '0;
            for (int i = 0; i < NSLOT; i++) begin
                qcnt_q[i] <= '0;
                for (int k = 0; k < NPORT; k++) qid_q[i][k] <= '0;
            end
        end else begin
            slot_q <= slot_n;
            park_q <= park_n;
            qcnt_q <= qcnt_n;
            qid_q  <= qid_n;
        end
    end

    assign parked = park_q;

    assert_reset_clean_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (slot_q == '0 && park_q == '0));

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot_chk
        assert_waiters_hold_R8: assert property (@(posedge clk) disable iff (rst)
            (qcnt_q[g] != '0) |-> slot_q[g]);
        assert_queue_bound_R8: assert property (@(posedge clk) disable iff (rst)
            qcnt_q[g] <= CW'(NPORT));
    end

endmodule

// File: rtl/lkeng_resp.sv
module lkeng_resp
    import lkeng_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  lk_rsp_t       nx,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_err
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= nx.vld;
            rsp_rdata <= {{(DW-1){1'b0}}, nx.held};
            rsp_err   <= nx.err;
        end
    end

endmodule

// File: rtl/lkeng_top.sv
module lkeng_top
    import lkeng_pkg::*;
#(
    parameter int NSLOT = 32,
    parameter int NPORT = 4,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                park_en,
    input  logic [NPORT-1:0]    req_valid,
    output logic [NPORT-1:0]    req_ready,
    input  logic [NPORT-1:0]    req_write,
    input  logic [NPORT*AW-1:0] req_addr,
    output logic [NPORT-1:0]    rsp_valid,
    output logic [NPORT*DW-1:0] rsp_rdata,
    output logic [NPORT-1:0]    rsp_err
);

    localparam int SW = lk_bits(NSLOT);
    localparam int PW = lk_bits(NPORT);
    localparam int CW = $clog2(NPORT + 1);

    lk_op_e           op   [NPORT];
    logic [SW-1:0]    slot [NPORT];
    lk_rsp_t          rsp  [NPORT];
    logic [NPORT-1:0] parked;

    lkeng_core #(
        .NSLOT(NSLOT), .NPORT(NPORT), .SW(SW), .PW(PW), .CW(CW)
    ) u_core (
        .clk    (clk),
        .rst    (rst),
        .park_en(park_en),
        .op     (op),
        .slot   (slot),
        .rsp    (rsp),
        .parked (parked)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_port
        lkeng_decode #(.NSLOT(NSLOT), .AW(AW), .SW(SW)) u_dec (
            .valid (req_valid[g]),
            .parked(parked[g]),
            .write (req_write[g]),
            .addr  (req_addr[g*AW +: AW]),
            .op    (op[g]),
            .slot  (slot[g])
        );

        lkeng_resp #(.DW(DW)) u_rsp (
            .clk      (clk),
            .rst      (rst),
            .nx       (rsp[g]),
            .rsp_valid(rsp_valid[g]),
            .rsp_rdata(rsp_rdata[g*DW +: DW]),
            .rsp_err  (rsp_err[g])
        );

        assign req_ready[g] = !parked[g];

        assert_single_cycle_R6: assert property (@(posedge clk) disable iff (rst)
            (req_valid[g] && req_ready[g] && !park_en) |=> rsp_valid[g]);
        assert_parked_silent_R7: assert property (@(posedge clk) disable iff (rst)
            !req_ready[g] |-> !rsp_valid[g]);
    end

endmodule

// File: tb/tb_lkeng_top.sv
module tb_lkeng_top;
    localparam int NP = 4;
    localparam int AW = 8;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic park_en = 1'b0;
    logic [NP-1:0]    req_valid = '0;
    logic [NP-1:0]    req_write = '0;
    logic [NP*AW-1:0] req_addr  = '0;
    logic [NP-1:0]    req_ready, rsp_valid, rsp_err;
    logic [NP*DW-1:0] rsp_rdata;

    int n_chk = 0;
    int n_bad = 0;

    lkeng_top #(.NSLOT(32), .NPORT(NP), .AW(AW), .DW(DW)) dut (
        .clk(clk), .rst(rst), .park_en(park_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] rd(input int p);
        return rsp_rdata[p*DW +: DW];
    endfunction

    task automatic drive(input int p, input bit wr, input int a);
        req_valid[p] = 1'b1;
        req_write[p] = wr;
        req_addr[p*AW +: AW] = a[AW-1:0];
    endtask

    // one edge: requests accepted, then sample at the following falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        req_valid = '0;
    endtask

    task automatic op1(input int p, input bit wr, input int a);
        drive(p, wr, a);
        step();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic t_reset();
        check("R9 ready after reset", 64'(req_ready), 64'hF);
        check("R9 no response after reset", 64'(rsp_valid), 64'h0);
        op1(0, 0, 0);
        check("R9 slot 0 free", 64'(rd(0)), 0);
        op1(1, 0, 31);
        check("R9 slot 31 free", 64'(rd(1)), 0);
        op1(0, 1, 0);
        op1(1, 1, 31);
    endtask

    task automatic t_acquire();
        op1(2, 0, 5);
        check("R1 first read valid", 64'(rsp_valid[2]), 1);
        check("R1 first read gets 0", 64'(rd(2)), 0);
        op1(2, 0, 5);
        check("R6 held read answered", 64'(rsp_valid[2]), 1);
        check("R1 second read gets 1, upper bits 0", 64'(rd(2)), 1);
    endtask

    task automatic t_release();
        op1(3, 1, 5);
        check("R2 write response valid", 64'(rsp_valid[3]), 1);
        check("R2 write no error", 64'(rsp_err[3]), 0);
        check("R2 write data 0", 64'(rd(3)), 0);
        op1(2, 0, 5);
        check("R2 slot free after write", 64'(rd(2)), 0);
        op1(3, 1, 5);
        op1(3, 1, 5);
        op1(2, 0, 5);
        check("R2 repeated write keeps slot free", 64'(rd(2)), 0);
        op1(3, 1, 5);
    endtask

    task automatic t_independent();
        op1(0, 0, 6);
        op1(1, 0, 7);
        check("R3 slot 7 free while 6 held", 64'(rd(1)), 0);
        op1(0, 1, 6);
        op1(1, 0, 7);
        check("R3 slot 7 still held after 6 released", 64'(rd(1)), 1);
        op1(0, 0, 6);
        check("R3 slot 6 free after own release", 64'(rd(0)), 0);
        op1(1, 1, 7);
        op1(0, 1, 6);
    endtask

    task automatic t_range();
        op1(1, 0, 37);
        check("R4 read out of range errors", 64'(rsp_err[1]), 1);
        check("R4 error data 0", 64'(rd(1)), 0);
        op1(2, 0, 5);
        check("R4 aliased slot 5 untouched", 64'(rd(2)), 0);
        op1(0, 0, 8);
        op1(1, 1, 40);
        check("R4 write out of range errors", 64'(rsp_err[1]), 1);
        op1(0, 0, 8);
        check("R4 aliased slot 8 still held", 64'(rd(0)), 1);
        op1(3, 0, 255);
        check("R4 top address errors", 64'(rsp_err[3]), 1);
        op1(2, 1, 5);
        op1(0, 1, 8);
    endtask

    task automatic t_same_cycle();
        for (int p = 0; p < NP; p++) drive(p, 0, 9);
        step();
        check("R5 all answered", 64'(rsp_valid), 64'hF);
        check("R5 port 0 wins", 64'(rd(0)), 0);
        check("R5 port 1 loses", 64'(rd(1)), 1);
        check("R5 port 2 loses", 64'(rd(2)), 1);
        check("R5 port 3 loses", 64'(rd(3)), 1);
        drive(1, 1, 9);
        drive(2, 0, 9);
        step();
        check("R5 lower-ID write before read", 64'(rd(2)), 0);
        drive(2, 0, 9);
        drive(3, 1, 9);
        step();
        check("R5 lower-ID read before write", 64'(rd(2)), 1);
        op1(0, 0, 9);
        check("R5 slot cleared by later write", 64'(rd(0)), 0);
        op1(0, 1, 9);
    endtask

    task automatic t_park();
        park_en = 1'b1;
        op1(0, 0, 3);
        check("R7 free slot answered at once", 64'(rd(0)), 0);
        op1(1, 0, 3);
        check("R7 parked read no response", 64'(rsp_valid[1]), 0);
        check("R7 parked ready low", 64'(req_ready[1]), 0);
        op1(2, 0, 3);
        step();
        step();
        check("R7 still silent", 64'(rsp_valid & 4'b0110), 0);
        op1(3, 1, 3);
        check("R8 writer and oldest waiter answered", 64'(rsp_valid), 64'b1010);
        check("R8 waiter gets 0", 64'(rd(1)), 0);
        check("R8 readies", 64'(req_ready), 64'b1011);
        op1(3, 1, 3);
        check("R8 second waiter granted", 64'(rsp_valid), 64'b1100);
        check("R8 second waiter gets 0", 64'(rd(2)), 0);
        op1(3, 1, 3);
        op1(0, 0, 3);
        check("R8 slot freed once queue empty", 64'(rd(0)), 0);
    endtask

    task automatic t_fifo();
        op1(2, 0, 3);
        op1(1, 0, 3);
        check("R8 both parked", 64'(req_ready), 64'b1001);
        op1(0, 1, 3);
        check("R8 earlier arrival port 2 granted", 64'(rsp_valid), 64'b0101);
        check("R8 port 1 still parked", 64'(req_ready[1]), 0);
        op1(0, 0, 3);
        check("R8 slot stays held for waiter", 64'(rsp_valid[0]), 0);
        op1(3, 1, 3);
        check("R8 port 1 granted next", 64'(rsp_valid), 64'b1010);
        op1(3, 1, 3);
        check("R8 port 0 granted last", 64'(rsp_valid), 64'b1001);
        check("R8 port 0 gets 0", 64'(rd(0)), 0);
        op1(0, 1, 3);
        park_en = 1'b0;
    endtask

    task automatic t_nonblock();
        op1(0, 0, 12);
        op1(1, 0, 12);
        check("R6 failed acquire answered", 64'(rsp_valid[1]), 1);
        check("R6 failed acquire returns 1", 64'(rd(1)), 1);
        check("R6 no stall", 64'(req_ready[1]), 1);
        op1(0, 1, 12);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_acquire();
        t_release();
        t_independent();
        t_range();
        t_same_cycle();
        t_park();
        t_fifo();
        t_nonblock();
        summary();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

endmodule